// File: doc/BRIEF.md
# Compare Flags and Branch Condition Evaluator

This unit produces the status flags of a compare or a test between two operands at an 8-, 16- or 32-bit width. It also decides whether a conditional branch is taken, from a 4-bit condition code and a separately supplied flags word. A compare subtracts the second operand from the first. A test ANDs the two operands. In both cases only the flags are kept and the arithmetic result is dropped. The second operand can be a signed byte immediate, which the unit widens to the selected width. The flag part and the condition part are independent, so a pipeline can evaluate one instruction's branch while it computes flags for the next.

Every output is registered once, so results appear on the clock edge that follows the inputs. Updating the program counter and fetching instructions are left to the surrounding logic.

Top module: `cmpbr_unit`

## Requirements
- R1: While rst_ni is low, all six outputs are 0, and they remain 0 until the first rising clock edge after reset is released.
- R2: Every output reflects the inputs sampled at the most recent rising clock edge, so each result appears exactly one cycle after its stimulus.
- R3: With is_test_i low (compare), the unit forms op_a minus op_b at the selected width. ZF is 1 when that difference is zero. SF is its top bit. CF is 1 when op_a is below op_b as unsigned numbers.
- R4: On a compare, OF is 1 when the signed difference does not fit the width. At 8 bits, 0xFE minus 0x7F gives OF=1 and SF=0, while 0x7F minus 0xFF gives OF=1 and SF=1.
- R5: When sext_b_i is 1, op_b_i[7:0] is sign-extended to the selected width before use, and op_b_i[31:8] has no effect.
- R6: With is_test_i high (test), the flags come from op_a AND op_b. ZF and SF are set from that result, and CF and OF are 0.
- R7: PF is 1 when bits [7:0] of the result (the difference or the AND) hold an even number of ones.
- R8: width_i encodes 0 as 8 bits and 1 as 16 bits; 2 and 3 both mean 32 bits. Operand bits above the selected width have no effect on any flag.
- R9: cond_flags_i carries CF in bit 0, PF in bit 1, ZF in bit 2, SF in bit 3 and OF in bit 4. Codes 2k and 2k+1 test opposite senses of the same condition, with bit 0 of cond_i inverting. Codes 0/1 test OF=1, 4/5 test ZF=1, 8/9 test SF=1 and 10/11 test PF=1.
- R10: The signed conditions are: code 12 is taken when SF differs from OF (less), code 13 is its inverse, code 14 is taken when ZF=1 or SF differs from OF (less or equal), and code 15 is its inverse (greater).
- R11: The unsigned conditions are: code 2 is taken when CF=1 (below), code 3 is its inverse, code 6 is taken when CF=1 or ZF=1 (below or equal), and code 7 is its inverse (above).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand, or byte immediate in [7:0] |
| width_i | input | 2 | Operand width select |
| is_test_i | input | 1 | 1 selects test (AND), 0 selects compare (subtract) |
| sext_b_i | input | 1 | Sign-extend op_b_i[7:0] to the selected width |
| cond_i | input | 4 | Branch condition code |
| cond_flags_i | input | 5 | Flags word that the condition is evaluated against |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| cf_o | output | 1 | Carry/borrow flag |
| of_o | output | 1 | Signed overflow flag |
| pf_o | output | 1 | Even parity of the low result byte |
| take_o | output | 1 | Branch condition result |

## Verification
All five flags and the take decision are due one rising edge after their inputs are applied. None of them depends on earlier stimulus. The bench drives a new set of inputs on each falling edge and compares every output with its behavioural model on the next falling edge, which is exactly one register stage later. The flag stimulus and the condition stimulus are applied together, so every cycle checks both parts of the unit.

// File: rtl/cmpbr_pkg.sv
package cmpbr_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned NUM_W   = 3;
  localparam int unsigned IMM_W   = 8;
  localparam int unsigned COND_W  = 4;

  typedef enum logic [1:0] {
    WID_8   = 2'd0,
    WID_16  = 2'd1,
    WID_32  = 2'd2,
    WID_32X = 2'd3
  } width_e;

  // cond_i[3:1]; cond_i[0] inverts
  typedef enum logic [2:0] {
    PAIR_OVF  = 3'd0,
    PAIR_BLW  = 3'd1,
    PAIR_EQ   = 3'd2,
    PAIR_BE   = 3'd3,
    PAIR_SGN  = 3'd4,
    PAIR_PAR  = 3'd5,
    PAIR_LT   = 3'd6,
    PAIR_LE   = 3'd7
  } pair_e;

  // bit4..bit0 = of, sf, zf, pf, cf
  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic pf;
    logic cf;
  } flags_t;
endpackage

// File: rtl/cmpbr_operand.sv
module cmpbr_operand
  import cmpbr_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  width_e         width_i,
  input  logic           sext_i,
  output logic [DW-1:0]  a_o,
  output logic [DW-1:0]  b_o,
  output logic [DW-1:0]  mask_o,
  output logic [$clog2(DW)-1:0] msb_o
);
  localparam int unsigned IW = $clog2(DW);

  logic [DW-1:0] mask_tbl [NUM_W];
  logic [IW-1:0] msb_tbl  [NUM_W];

  for (genvar g = 0; g < NUM_W; g++) begin : g_tbl
    localparam int unsigned BITS = IMM_W << g;
    assign mask_tbl[g] = (BITS >= DW) ? {DW{1'b1}} : DW'((64'd1 << BITS) - 64'd1);
    assign msb_tbl[g]  = IW'(BITS - 1);
  end

  logic [1:0]    sel;
  logic [DW-1:0] b_ext;

  always_comb begin
    unique case (width_i)
      WID_8:   sel = 2'd0;
      WID_16:  sel = 2'd1;
      default: sel = 2'd2;
    endcase
    b_ext  = sext_i ? {{(DW-IMM_W){b_i[IMM_W-1]}}, b_i[IMM_W-1:0]} : b_i;
    mask_o = mask_tbl[sel];
    msb_o  = msb_tbl[sel];
    a_o    = a_i & mask_o;
    b_o    = b_ext & mask_o;
  end
endmodule

// File: rtl/cmpbr_flag_gen.sv
module cmpbr_flag_gen
  import cmpbr_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic [DW-1:0]         a_i,
  input  logic [DW-1:0]         b_i,
  input  logic [DW-1:0]         mask_i,
  input  logic [$clog2(DW)-1:0] msb_i,
  input  logic                  is_test_i,
  output flags_t                flags_o
);
  logic [DW-1:0] diff;
  logic [DW-1:0] res;
  logic          top_r, top_a, top_b;

  always_comb begin
    diff  = (a_i - b_i) & mask_i;
    res   = is_test_i ? (a_i & b_i) : diff;
    top_r = res[msb_i];
    top_a = a_i[msb_i];
    top_b = b_i[msb_i];

    flags_o.zf = (res == '0);
    flags_o.sf = top_r;
    flags_o.pf = ~^res[IMM_W-1:0];
    flags_o.cf = !is_test_i && (a_i < b_i);
    // operands of unlike sign, result sign differs from minuend
    flags_o.of = !is_test_i && (top_a ^ top_b) && (top_r ^ top_a);
  end
endmodule

// File: rtl/cmpbr_cond_eval.sv
module cmpbr_cond_eval
  import cmpbr_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  flags_t            flags_i,
  output logic              take_o
);
  pair_e pair;
  logic  base;
  logic  lt;

  always_comb begin
    pair = pair_e'(cond_i[COND_W-1:1]);
    lt   = flags_i.sf ^ flags_i.of;
    unique case (pair)
      PAIR_OVF: base = flags_i.of;
      PAIR_BLW: base = flags_i.cf;
      PAIR_EQ:  base = flags_i.zf;
      PAIR_BE:  base = flags_i.cf | flags_i.zf;
      PAIR_SGN: base = flags_i.sf;
      PAIR_PAR: base = flags_i.pf;
      PAIR_LT:  base = lt;
      PAIR_LE:  base = lt | flags_i.zf;
      default:  base = 1'b0;
    endcase
    take_o = base ^ cond_i[0];
  end
endmodule

// File: rtl/cmpbr_unit.sv
module cmpbr_unit
  import cmpbr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [1:0]        width_i,
  input  logic              is_test_i,
  input  logic              sext_b_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic [4:0]        cond_flags_i,
  output logic              zf_o,
  output logic              sf_o,
  output logic              cf_o,
  output logic              of_o,
  output logic              pf_o,
  output logic              take_o
);
  localparam int unsigned IW = $clog2(DATA_W);

  logic [DATA_W-1:0] a_m, b_m, mask;
  logic [IW-1:0]     msb;
  flags_t            flags_d, flags_q;
  logic              take_d, take_q;

  cmpbr_operand #(.DW(DATA_W)) u_operand (
    .a_i     (op_a_i),
    .b_i     (op_b_i),
    .width_i (width_e'(width_i)),
    .sext_i  (sext_b_i),
    .a_o     (a_m),
    .b_o     (b_m),
    .mask_o  (mask),
    .msb_o   (msb)
  );

  cmpbr_flag_gen #(.DW(DATA_W)) u_flag_gen (
    .a_i       (a_m),
    .b_i       (b_m),
    .mask_i    (mask),
    .msb_i     (msb),
    .is_test_i (is_test_i),
    .flags_o   (flags_d)
  );

  cmpbr_cond_eval u_cond_eval (
    .cond_i  (cond_i),
    .flags_i (flags_t'(cond_flags_i)),
    .take_o  (take_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      take_q  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      take_q  <= take_d;
    end
  end

  assign zf_o   = flags_q.zf;
  assign sf_o   = flags_q.sf;
  assign cf_o   = flags_q.cf;
  assign of_o   = flags_q.of;
  assign pf_o   = flags_q.pf;
  assign take_o = take_q;
endmodule

// File: rtl/cmpbr_unit_chk.sv
module cmpbr_unit_chk
  import cmpbr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] op_a_i,
  input logic [DATA_W-1:0] op_b_i,
  input logic [1:0]        width_i,
  input logic              is_test_i,
  input logic              sext_b_i,
  input logic [COND_W-1:0] cond_i,
  input logic [4:0]        cond_flags_i,
  input logic              zf_o,
  input logic              sf_o,
  input logic              cf_o,
  input logic              of_o,
  input logic              take_o
);
  logic primed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed <= 1'b0;
    else         primed <= 1'b1;
  end

  // R6
  test_clears_cf_of_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(is_test_i) |-> !cf_o && !of_o);

  // R3
  zero_not_negative_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zf_o |-> !sf_o);

  // R3
  equal_compare_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(!is_test_i && !sext_b_i && op_a_i == op_b_i) |-> zf_o && !cf_o && !of_o);

  // R11
  unsigned_borrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(!is_test_i && !sext_b_i && width_i[1]) |-> cf_o == $past(op_a_i < op_b_i));

  // R9
  equal_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(cond_i == 4'd4) |-> take_o == $past(cond_flags_i[2]));

  // R9
  pair_inverse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed && $past(cond_i == 4'd5) |-> take_o != $past(cond_flags_i[2]));
endmodule

bind cmpbr_unit cmpbr_unit_chk u_chk (.*);

// File: tb/cmpbr_unit_test.sv
`timescale 1ns/1ps
module cmpbr_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] op_a_i = '0, op_b_i = '0;
  logic [1:0]  width_i = '0;
  logic        is_test_i = 1'b0, sext_b_i = 1'b0;
  logic [3:0]  cond_i = '0;
  logic [4:0]  cond_flags_i = '0;
  logic        zf_o, sf_o, cf_o, of_o, pf_o, take_o;

  int errors = 0;
  int checks = 0;

  always #2 clk_i = ~clk_i;

  cmpbr_unit uut (.*);

  // returns {of, sf, zf, pf, cf}
  function automatic logic [4:0] ref_flags(logic [31:0] a, logic [31:0] b,
                                           logic [1:0] w, logic tst, logic sx);
    longint n, full, ua, ub, r, half, sa, sb, sd;
    logic of_r, sf_r, zf_r, pf_r, cf_r;
    int ones;
    n    = (w == 2'd0) ? 8 : (w == 2'd1) ? 16 : 32;
    full = longint'(1) << n;
    half = full / 2;
    if (sx) ub = (b[7] ? (longint'(b[7:0]) - 256 + full) : longint'(b[7:0])) % full;
    else    ub = longint'(b) % full;
    ua = longint'(a) % full;
    if (tst) begin
      r = ua & ub;
      cf_r = 0; of_r = 0;
    end else begin
      r = (ua - ub + full) % full;
      cf_r = (ua < ub);
      sa = (ua >= half) ? ua - full : ua;
      sb = (ub >= half) ? ub - full : ub;
      sd = sa - sb;
      of_r = (sd < -half) || (sd >= half);
    end
    zf_r = (r == 0);
    sf_r = (r >= half);
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'((r >> i) & 1);
    pf_r = (ones % 2 == 0);
    return {of_r, sf_r, zf_r, pf_r, cf_r};
  endfunction

  function automatic logic ref_take(logic [3:0] c, logic [4:0] f);
    logic cf_v, pf_v, zf_v, sf_v, of_v, t;
    cf_v = f[0]; pf_v = f[1]; zf_v = f[2]; sf_v = f[3]; of_v = f[4];
    case (c / 2)
      0: t = of_v;
      1: t = cf_v;
      2: t = zf_v;
      3: t = cf_v || zf_v;
      4: t = sf_v;
      5: t = pf_v;
      6: t = (sf_v != of_v);
      default: t = zf_v || (sf_v != of_v);
    endcase
    return (c % 2 == 1) ? !t : t;
  endfunction

  task automatic check(string req, logic [5:0] got, logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {of,sf,zf,pf,cf,take} actual=%b expected=%b", req, got, exp);
    end
  endtask

  // drive on falling edge, sample on the next falling edge (one register stage)
  task automatic step(string req, logic [31:0] a, logic [31:0] b, logic [1:0] w,
                      logic tst, logic sx, logic [3:0] c, logic [4:0] f);
    logic [4:0] ef;
    op_a_i = a; op_b_i = b; width_i = w; is_test_i = tst; sext_b_i = sx;
    cond_i = c; cond_flags_i = f;
    ef = ref_flags(a, b, w, tst, sx);
    @(negedge clk_i);
    check(req, {of_o, sf_o, zf_o, pf_o, cf_o, take_o}, {ef, ref_take(c, f)});
  endtask

  initial begin : watchdog
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: drive inputs that would set flags, outputs must stay low in reset
    op_a_i = 32'h1; op_b_i = 32'h2; cond_i = 4'd1; cond_flags_i = 5'd0;
    repeat (3) @(negedge clk_i);
    check("R1", {of_o, sf_o, zf_o, pf_o, cf_o, take_o}, 6'b0);
    rst_ni = 1'b1;
    #0.5;
    check("R1", {of_o, sf_o, zf_o, pf_o, cf_o, take_o}, 6'b0);
    @(negedge clk_i);

    // R4: 8-bit signed overflow cases
    step("R4", 32'hFE, 32'h7F, 2'd0, 0, 0, 4'd12, 5'b10000);
    step("R4", 32'h7F, 32'hFF, 2'd0, 0, 0, 4'd12, 5'b11000);
    // R3 at each width
    step("R3", 32'h1, 32'h2, 2'd2, 0, 0, 4'd2, 5'b00001);
    step("R3", 32'h8000, 32'h1, 2'd1, 0, 0, 4'd4, 5'b00100);
    step("R3", 32'h5, 32'h5, 2'd3, 0, 0, 4'd5, 5'b00100);
    // R8: bits above the width ignored
    step("R8", 32'hABCD_0005, 32'h1234_0005, 2'd0, 0, 0, 4'd0, 5'b0);
    step("R8", 32'hFFFF_0000, 32'h0000_0001, 2'd1, 0, 0, 4'd0, 5'b0);
    // R5: sign-extended immediate
    step("R5", 32'h0000_FFFF, 32'h1234_56FF, 2'd1, 0, 1, 4'd0, 5'b0);
    step("R5", 32'h0000_FFFF, 32'h0000_00FF, 2'd1, 0, 0, 4'd0, 5'b0);
    step("R5", 32'h0000_0010, 32'hFFFF_FF05, 2'd2, 0, 1, 4'd0, 5'b0);
    // R6: test mode
    step("R6", 32'hF0F0_F0F0, 32'h0F0F_0F0F, 2'd2, 1, 0, 4'd0, 5'b0);
    step("R6", 32'h8000_0000, 32'hFFFF_FFFF, 2'd2, 1, 0, 4'd0, 5'b0);
    // R7: parity of low byte
    step("R7", 32'hFFFF_FF03, 32'hFFFF_FFFF, 2'd2, 1, 0, 4'd0, 5'b0);
    step("R7", 32'h0000_0008, 32'h0000_0001, 2'd0, 0, 0, 4'd0, 5'b0);

    // R9 R10 R11: every condition code against a spread of flag words
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 32; f += 3) begin
        string tag;
        tag = (c >= 12) ? "R10" : (c == 2 || c == 3 || c == 6 || c == 7) ? "R11" : "R9";
        step(tag, 32'h0, 32'h0, 2'd2, 0, 0, 4'(c), 5'(f));
      end
    end

    // R2: fresh stimulus every cycle, each result due one edge later
    for (int i = 0; i < 600; i++) begin
      step("R2", $urandom, (i % 5 == 0) ? 32'h0 : $urandom, 2'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           4'($urandom_range(0, 15)), 5'($urandom_range(0, 31)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule